// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Remainder

This block divides a dividend by a divisor over several clock cycles and returns both a quotient and a remainder. Each operand carries its own signedness flag. When the flag is set, the operand is read as a two's complement value. When the flag is clear, the operand is zero-extended. The core works on the operand magnitudes with a restoring shift-subtract loop that yields one quotient bit per clock. A final state then applies the signs.

Results follow truncating integer division. The quotient is negative when exactly one operand is negative. The remainder always carries the dividend's sign. Both results are reduced modulo 2^RES_W, and RES_W defaults to the wider operand width. A zero divisor skips the loop entirely. It raises a flag and returns an all-ones pattern in both results.

The state machine has three states.
- `ST_IDLE` waits for work. The transition *accept* moves it on when `start` is seen; it goes to `ST_SHIFT` for a nonzero divisor and straight to `ST_FIX` for a zero divisor.
- `ST_SHIFT` runs one restoring step per cycle. Its transition *last_step* goes to `ST_FIX` after CORE_W steps.
- `ST_FIX` writes the signed results and pulses `done`. Its transition *retire* returns to `ST_IDLE`.

Top module: `divmod_unit`

## Requirements
- R1: After reset, busy, done and div_zero are 0, and quo and rem are all zeros.
- R2: With both signedness flags clear, the operands are unsigned and results are the truncated quotient and remainder (for example 200/7 gives 28 remainder 4).
- R3: An operand whose signedness flag is 1 is read as two's complement. An operand whose flag is 0 is zero-extended, so 0xF9 means -7 when signed and 249 when unsigned.
- R4: The quotient is negative exactly when the two operand values have opposite signs, and it is returned in two's complement.
- R5: The remainder takes the sign of the dividend whatever the divisor's sign, and its magnitude is less than the divisor's magnitude.
- R6: A divisor of zero sets div_zero to 1 and drives every bit of quo and rem to 1. In that case done rises at the first rising edge after the edge that accepts start.
- R7: For a nonzero divisor, done rises at the (CORE_W+1)th rising edge after the edge that accepts start, where CORE_W is the wider operand width. busy is 1 from the accepting edge until the edge that raises done. done is a one-cycle pulse.
- R8: start is ignored while busy is 1. Operands presented then do not alter the running division, and no extra done follows.
- R9: The most negative signed dividend divided by signed -1 wraps modulo 2^RES_W (0x80 for 8 bits), with remainder 0 and div_zero 0.
- R10: quo, rem and div_zero change only on the edge that raises done. div_zero returns to 0 for the next division with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only when busy is 0 |
| dvd | input | DVD_W | Dividend |
| dvd_signed | input | 1 | 1: dividend is two's complement |
| dvs | input | DVS_W | Divisor |
| dvs_signed | input | 1 | 1: divisor is two's complement |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quo | output | RES_W | Quotient, registered |
| rem | output | RES_W | Remainder, registered |
| div_zero | output | 1 | The last division had a zero divisor |

## Verification
The dividends and divisors are chosen so that each sign combination gives a different answer. Plain unsigned pairs establish the magnitude loop on its own. The pattern 0xF9 is applied both with and without its signedness flag, which separates two's complement reading from zero extension. Pairs with both operands negative, only the dividend negative and only the divisor negative separate the quotient sign rule from the remainder sign rule. A zero divisor (signed and unsigned), the most negative dividend over -1, a dividend smaller than the divisor, and a second start presented while busy cover the edge cases, and the latency of each result is compared with the expected edge count.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FIX   = 2'd2
    } div_state_e;

    function automatic int width_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/div_operand_mag.sv
// Turns one operand into a CORE_W-bit magnitude and a negative flag.
module div_operand_mag #(
    parameter int IN_W   = 8,
    parameter int CORE_W = 8
) (
    input  logic [IN_W-1:0]   value,
    input  logic              as_signed,
    output logic [CORE_W-1:0] mag,
    output logic              is_neg
);
    logic [CORE_W-1:0] widened;

    assign is_neg = as_signed & value[IN_W-1];

    generate
        if (IN_W < CORE_W) begin : g_extend
            assign widened = {{(CORE_W-IN_W){is_neg}}, value};
        end else begin : g_same
            assign widened = value;
        end
    endgenerate

    assign mag = is_neg ? (~widened + 1'b1) : widened;
endmodule

// File: rtl/div_restore_step.sv
// One restoring iteration: shift in the next dividend bit, trial subtract.
module div_restore_step #(
    parameter int CORE_W = 8
) (
    input  logic [CORE_W-1:0] part_in,
    input  logic [CORE_W-1:0] bits_in,
    input  logic [CORE_W-1:0] divisor,
    output logic [CORE_W-1:0] part_out,
    output logic [CORE_W-1:0] bits_out
);
    logic [CORE_W:0] shifted;
    logic [CORE_W:0] trial;
    logic            fits;

    assign shifted  = {part_in, bits_in[CORE_W-1]};
    assign trial    = shifted - {1'b0, divisor};
    assign fits     = ~trial[CORE_W];
    assign part_out = fits ? trial[CORE_W-1:0] : shifted[CORE_W-1:0];
    assign bits_out = {bits_in[CORE_W-2:0], fits};
endmodule

// File: rtl/div_result_fix.sv
// Applies a sign to a magnitude and reduces it modulo 2^RES_W.
module div_result_fix #(
    parameter int CORE_W = 8,
    parameter int RES_W  = 8
) (
    input  logic [CORE_W-1:0] mag,
    input  logic              make_neg,
    output logic [RES_W-1:0]  result
);
    localparam int FIX_W = (CORE_W > RES_W) ? CORE_W : RES_W;

    logic [FIX_W-1:0] widened;
    logic [FIX_W-1:0] signed_val;

    generate
        if (CORE_W < FIX_W) begin : g_extend
            assign widened = {{(FIX_W-CORE_W){1'b0}}, mag};
        end else begin : g_same
            assign widened = mag;
        end
    endgenerate

    assign signed_val = make_neg ? (~widened + 1'b1) : widened;
    assign result     = signed_val[RES_W-1:0];
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
    import divmod_pkg::*;
#(
    parameter int DVD_W = 8,
    parameter int DVS_W = 8,
    parameter int RES_W = width_max(DVD_W, DVS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dvd,
    input  logic             dvd_signed,
    input  logic [DVS_W-1:0] dvs,
    input  logic             dvs_signed,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] quo,
    output logic [RES_W-1:0] rem,
    output logic             div_zero
);
    localparam int CORE_W = width_max(DVD_W, DVS_W);
    localparam int CNT_W  = $clog2(CORE_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CORE_W - 1);

    div_state_e state_q, state_d;

    logic [CORE_W-1:0] mag_dvd, mag_dvs;
    logic              neg_dvd, neg_dvs;
    logic              dvs_zero;

    logic [CORE_W-1:0] part_q, bits_q, divisor_q;
    logic [CORE_W-1:0] part_nx, bits_nx;
    logic [CNT_W-1:0]  step_q;
    logic              neg_quo_q, neg_rem_q, zero_q;
    logic [RES_W-1:0]  quo_fix, rem_fix;

    div_operand_mag #(.IN_W(DVD_W), .CORE_W(CORE_W)) u_mag_dvd (
        .value(dvd), .as_signed(dvd_signed), .mag(mag_dvd), .is_neg(neg_dvd)
    );
    div_operand_mag #(.IN_W(DVS_W), .CORE_W(CORE_W)) u_mag_dvs (
        .value(dvs), .as_signed(dvs_signed), .mag(mag_dvs), .is_neg(neg_dvs)
    );

    assign dvs_zero = (dvs == '0);

    div_restore_step #(.CORE_W(CORE_W)) u_step (
        .part_in(part_q), .bits_in(bits_q), .divisor(divisor_q),
        .part_out(part_nx), .bits_out(bits_nx)
    );

    div_result_fix #(.CORE_W(CORE_W), .RES_W(RES_W)) u_fix_quo (
        .mag(bits_q), .make_neg(neg_quo_q), .result(quo_fix)
    );
    div_result_fix #(.CORE_W(CORE_W), .RES_W(RES_W)) u_fix_rem (
        .mag(part_q), .make_neg(neg_rem_q), .result(rem_fix)
    );

    // Transitions: accept, last_step, retire.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = dvs_zero ? ST_FIX : ST_SHIFT;
            ST_SHIFT: if (step_q == '0) state_d = ST_FIX;
            ST_FIX:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q    <= '0;
            bits_q    <= '0;
            divisor_q <= '0;
            step_q    <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
            done      <= 1'b0;
            quo       <= '0;
            rem       <= '0;
            div_zero  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        part_q    <= '0;
                        bits_q    <= mag_dvd;
                        divisor_q <= mag_dvs;
                        step_q    <= LAST_IDX;
                        neg_quo_q <= neg_dvd ^ neg_dvs;
                        neg_rem_q <= neg_dvd;
                        zero_q    <= dvs_zero;
                    end
                end
                ST_SHIFT: begin
                    part_q <= part_nx;
                    bits_q <= bits_nx;
                    step_q <= step_q - 1'b1;
                end
                ST_FIX: begin
                    done     <= 1'b1;
                    div_zero <= zero_q;
                    quo      <= zero_q ? '1 : quo_fix;
                    rem      <= zero_q ? '1 : rem_fix;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/divmod_unit_chk.sv
module divmod_unit_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             div_zero,
    input logic [RES_W-1:0] quo,
    input logic [RES_W-1:0] rem
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_zero_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> ((&quo) && (&rem)));

    assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem) && $stable(div_zero)));
endmodule

bind divmod_unit divmod_unit_chk #(.RES_W(RES_W)) u_divmod_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .div_zero(div_zero), .quo(quo), .rem(rem)
);

// File: tb/test_divmod_unit.sv
module test_divmod_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dvd = '0;
    logic         dvd_signed = 1'b0;
    logic [W-1:0] dvs = '0;
    logic         dvs_signed = 1'b0;
    logic         busy, done, div_zero;
    logic [W-1:0] quo, rem;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit prev_done = 1'b0;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        bit           dz;
        int           due;
        string        tag;
    } exp_t;

    exp_t sb[$];

    divmod_unit #(.DVD_W(W), .DVS_W(W)) i_divmod_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd(dvd), .dvd_signed(dvd_signed), .dvs(dvs), .dvs_signed(dvs_signed),
        .busy(busy), .done(done), .quo(quo), .rem(rem), .div_zero(div_zero)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pop the scoreboard on every done pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(quo == e.q, e.tag, "quotient", quo, e.q);
                    check(rem == e.r, e.tag, "remainder", rem, e.r);
                    check(div_zero == e.dz, e.tag, "div_zero", div_zero, e.dz);
                    check(cyc == e.due, "R7", "done cycle", cyc, e.due);
                end
            end
            if (prev_done && done) check(1'b0, "R7", "done longer than one cycle", 1, 0);
            prev_done = done;
        end
    end

    task automatic issue(input logic [W-1:0] a, input bit as, input logic [W-1:0] b,
                         input bit bs, input string tag, input bit poke);
        exp_t e;
        int va, vb;
        @(negedge clk);
        va = as ? int'($signed(a)) : int'(a);
        vb = bs ? int'($signed(b)) : int'(b);
        e.tag = tag;
        if (vb == 0) begin
            e.q = '1; e.r = '1; e.dz = 1'b1;
            e.due = cyc + 2;
        end else begin
            e.q = W'(va / vb); e.r = W'(va % vb); e.dz = 1'b0;
            e.due = cyc + 1 + W + 1;
        end
        sb.push_back(e);
        dvd = a; dvd_signed = as; dvs = b; dvs_signed = bs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after accept", busy, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            check(busy == 1'b1, "R8", "busy at second start", busy, 1);
            dvd = 8'd3; dvd_signed = 1'b0; dvs = 8'd0; dvs_signed = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(done == 1'b0, "R1", "done", done, 0);
        check(quo == '0, "R1", "quo", quo, 0);
        check(rem == '0, "R1", "rem", rem, 0);
        check(div_zero == 1'b0, "R1", "div_zero", div_zero, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(8'd200, 0, 8'd7,   0, "R2", 0);
        issue(8'd255, 0, 8'd1,   0, "R2", 0);
        issue(8'd3,   0, 8'd10,  0, "R2", 0);
        issue(8'hF9,  1, 8'd2,   1, "R3", 0);
        issue(8'hF9,  1, 8'd2,   0, "R3", 0);
        issue(8'hF9,  0, 8'hFE,  1, "R3", 0);
        issue(8'hF9,  1, 8'hFE,  1, "R4", 0);
        issue(8'd100, 1, 8'hF3,  1, "R4", 0);
        issue(8'd7,   1, 8'hFE,  1, "R5", 0);
        issue(8'h81,  1, 8'd10,  1, "R5", 0);
        issue(8'd5,   0, 8'd0,   0, "R6", 0);
        issue(8'h80,  1, 8'd0,   1, "R6", 0);
        issue(8'd100, 0, 8'd9,   0, "R10", 0);
        issue(8'h80,  1, 8'hFF,  1, "R9", 0);
        issue(8'd250, 0, 8'd13,  0, "R8", 1);

        repeat (W + 4) @(negedge clk);
        check(sb.size() == 0, "R8", "pending results", sb.size(), 0);
        check(busy == 1'b0, "R8", "busy after extra start", busy, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 0, 1);
        finish_run();
    end
endmodule